// File: doc/BRIEF.md
# Resetting Confidence Counter Table

This block keeps a small confidence counter for every slot of a branch prediction table and is addressed with the same index as that table. Each counter records how many times in a row the prediction for its slot was right. A correct outcome adds one to the counter until it reaches the top value. A wrong outcome sets the counter straight back to zero, so the counter never counts down step by step. When reset ends, every counter holds its top value, so no warm-up is needed before speculation can start.

A lookup port takes a branch index, a flag that marks the branch as data-dependent, and a threshold. One cycle later the block returns the counter value and a confident flag. For a data-dependent branch it also returns a decision: stall fetch until the branch resolves, or allow speculation past it. An update port takes an index and a correct/incorrect flag once the branch target is known. A threshold of zero makes every branch confident, which turns the gating off.

Top module: `conf_table_top`

## Requirements
- R1: After reset every counter holds 15, the saturated value of the 4-bit counter.
- R2: An update with the correct flag set adds one to the counter at the given index.
- R3: An update with the correct flag set holds a counter that is already at 15.
- R4: An update with the correct flag clear sets the counter at the given index to 0.
- R5: The confident flag is 1 exactly when the counter value is greater than or equal to the threshold given with the lookup; a threshold of 0 always gives confident.
- R6: A lookup returns its result in the cycle after the request, marked by the response-valid output; without a request, response-valid is 0.
- R7: When an update and a lookup name the same index in the same cycle, the lookup returns the counter value from before that update.
- R8: For a data-dependent lookup, fetch_stall is 1 when the branch is not confident and spec_allow is 1 when it is confident; the two are never 1 together.
- R9: For a lookup that is not data-dependent, and in cycles without a response, fetch_stall and spec_allow are both 0.
- R10: An update changes only the counter at its own index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | IDX_W | Lookup index |
| lk_dep | input | 1 | Looked-up branch is data-dependent |
| lk_thresh | input | 4 | Confidence threshold for this lookup |
| upd_valid | input | 1 | Update request |
| upd_idx | input | IDX_W | Update index |
| upd_hit | input | 1 | 1 = prediction was correct, 0 = mispredicted |
| rsp_valid | output | 1 | Lookup result valid (one cycle after request) |
| rsp_count | output | 4 | Counter value seen by the lookup |
| rsp_conf | output | 1 | Branch is confident |
| fetch_stall | output | 1 | Stall fetch until the branch resolves |
| spec_allow | output | 1 | Speculation past the branch is allowed |

## Verification
The assertions take for granted that every input is driven to a known level from time zero and through reset, because the clearing check looks one cycle back at the update port and the threshold check looks one cycle back at the lookup threshold. They also assume that the threshold for a lookup is presented in the same cycle as the request. The stimulus keeps to this: the bench drives all inputs low from the start, changes them only on the falling clock edge, and presents each threshold together with its lookup.

// File: rtl/conf_pkg.sv
package conf_pkg;

    // Counter width: wide enough for a threshold of 8.
    localparam int CNT_W   = 4;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef logic [CNT_W-1:0] cnt_t;

    // Registered lookup result.
    typedef struct packed {
        logic valid;
        logic conf;
        logic dep;
        cnt_t cnt;
    } rsp_t;

    // Next value of one counter after an outcome.
    function automatic cnt_t cnt_next(input cnt_t cur, input logic hit);
        if (!hit)
            return '0;
        else if (cur == CNT_MAX)
            return cur;
        else
            return cur + cnt_t'(1);
    endfunction

endpackage

// File: rtl/conf_cnt_bank.sv
module conf_cnt_bank
    import conf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_hit,
    input  logic [IDX_W-1:0] rd_idx,
    output cnt_t             rd_cnt
);

    localparam int DEPTH = 1 << IDX_W;

    cnt_t cnt_d [DEPTH];
    cnt_t cnt_q [DEPTH];

    // One next-state slice per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_comb begin
            cnt_d[i] = cnt_q[i];
            if (upd_valid && upd_idx == IDX_W'(i))
                cnt_d[i] = cnt_next(cnt_q[i], upd_hit);
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q[i] <= CNT_MAX;
            else
                cnt_q[i] <= cnt_d[i];
        end
    end

    // Read sees the stored value, before any same-cycle update.
    assign rd_cnt = cnt_q[rd_idx];

endmodule

// File: rtl/conf_cmp.sv
module conf_cmp
    import conf_pkg::*;
(
    input  cnt_t cnt,
    input  cnt_t thresh,
    output logic conf
);

    always_comb begin
        if (thresh == '0)
            conf = 1'b1;
        else
            conf = (cnt >= thresh);
    end

endmodule

// File: rtl/conf_decide.sv
module conf_decide
    import conf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic dep,
    input  logic conf,
    input  cnt_t cnt,
    output rsp_t rsp,
    output logic stall,
    output logic spec
);

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req;
        if (req) begin
            rsp_d.conf = conf;
            rsp_d.dep  = dep;
            rsp_d.cnt  = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp   = rsp_q;
    assign stall = rsp_q.valid && rsp_q.dep && !rsp_q.conf;
    assign spec  = rsp_q.valid && rsp_q.dep &&  rsp_q.conf;

endmodule

// File: rtl/conf_table_top.sv
module conf_table_top
    import conf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             lk_dep,
    input  logic [3:0]       lk_thresh,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_hit,
    output logic             rsp_valid,
    output logic [3:0]       rsp_count,
    output logic             rsp_conf,
    output logic             fetch_stall,
    output logic             spec_allow
);

    cnt_t rd_cnt;
    logic rd_conf;
    rsp_t rsp;

    conf_cnt_bank #(.IDX_W(IDX_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_idx   (upd_idx),
        .upd_hit   (upd_hit),
        .rd_idx    (lk_idx),
        .rd_cnt    (rd_cnt)
    );

    conf_cmp u_cmp (
        .cnt    (rd_cnt),
        .thresh (lk_thresh),
        .conf   (rd_conf)
    );

    conf_decide u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (lk_valid),
        .dep   (lk_dep),
        .conf  (rd_conf),
        .cnt   (rd_cnt),
        .rsp   (rsp),
        .stall (fetch_stall),
        .spec  (spec_allow)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_count = rsp.cnt;
    assign rsp_conf  = rsp.conf;

endmodule

// File: rtl/conf_table_chk.sv
module conf_table_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [IDX_W-1:0] lk_idx,
    input logic [3:0]       lk_thresh,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_idx,
    input logic             upd_hit,
    input logic             rsp_valid,
    input logic [3:0]       rsp_count,
    input logic             rsp_conf,
    input logic             fetch_stall,
    input logic             spec_allow
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R6

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R6

    AST_CONF_VS_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_conf == (rsp_count >= $past(lk_thresh)))); // R5

    AST_STALL_SPEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_stall && spec_allow)); // R8

    AST_DECIDE_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall || spec_allow) |-> rsp_valid); // R9

    AST_MISS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(upd_valid && !upd_hit) && lk_idx == $past(upd_idx))
        |=> rsp_count == 4'd0); // R4

endmodule

bind conf_table_top conf_table_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .lk_idx      (lk_idx),
    .lk_thresh   (lk_thresh),
    .upd_valid   (upd_valid),
    .upd_idx     (upd_idx),
    .upd_hit     (upd_hit),
    .rsp_valid   (rsp_valid),
    .rsp_count   (rsp_count),
    .rsp_conf    (rsp_conf),
    .fetch_stall (fetch_stall),
    .spec_allow  (spec_allow)
);

// File: tb/sim_conf_table_top.sv
`timescale 1ns/1ps
module sim_conf_table_top;

    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [IDX_W-1:0] lk_idx = '0;
    logic             lk_dep = 1'b0;
    logic [3:0]       lk_thresh = '0;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_idx = '0;
    logic             upd_hit = 1'b0;
    logic             rsp_valid;
    logic [3:0]       rsp_count;
    logic             rsp_conf;
    logic             fetch_stall;
    logic             spec_allow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    conf_table_top #(.IDX_W(IDX_W)) u0 (.*);

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Drive a lookup at a falling edge; results are read at the next falling edge.
    task automatic lookup(input int idx, input bit dep, input int thr);
        lk_valid  = 1'b1;
        lk_idx    = IDX_W'(idx);
        lk_dep    = dep;
        lk_thresh = 4'(thr);
        @(negedge clk);
        lk_valid  = 1'b0;
        lk_dep    = 1'b0;
    endtask

    task automatic update(input int idx, input bit hit);
        upd_valid = 1'b1;
        upd_idx   = IDX_W'(idx);
        upd_hit   = hit;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R6", "rsp_valid idle", int'(rsp_valid), 0);
        chk("R9", "stall idle", int'(fetch_stall), 0);
        for (int i = 0; i < 64; i += 21) begin
            lookup(i, 1'b1, 8);
            chk("R1", "count after reset", int'(rsp_count), 15);
            chk("R8", "spec after reset", int'(spec_allow), 1);
        end
    endtask

    task automatic t_miss_clear();
        update(3, 1'b0);
        lookup(3, 1'b1, 1);
        chk("R4", "count after miss", int'(rsp_count), 0);
        chk("R5", "conf count0 thr1", int'(rsp_conf), 0);
        chk("R8", "stall when not confident", int'(fetch_stall), 1);
        chk("R8", "spec when not confident", int'(spec_allow), 0);
    endtask

    task automatic t_increment();
        for (int k = 0; k < 3; k++) update(3, 1'b1);
        lookup(3, 1'b1, 2);
        chk("R2", "count after 3 hits", int'(rsp_count), 3);
        chk("R5", "conf count3 thr2", int'(rsp_conf), 1);
        lookup(3, 1'b1, 4);
        chk("R5", "conf count3 thr4", int'(rsp_conf), 0);
        chk("R8", "stall count3 thr4", int'(fetch_stall), 1);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 20; k++) update(3, 1'b1);
        lookup(3, 1'b1, 8);
        chk("R3", "count saturated", int'(rsp_count), 15);
        chk("R5", "conf count15 thr8", int'(rsp_conf), 1);
    endtask

    task automatic t_thresh0();
        update(9, 1'b0);
        lookup(9, 1'b1, 0);
        chk("R5", "thr0 always confident", int'(rsp_conf), 1);
        chk("R8", "thr0 spec", int'(spec_allow), 1);
    endtask

    task automatic t_same_cycle();
        upd_valid = 1'b1; upd_idx = IDX_W'(12); upd_hit = 1'b0;
        lookup(12, 1'b1, 8);
        upd_valid = 1'b0;
        chk("R7", "pre-update value seen", int'(rsp_count), 15);
        lookup(12, 1'b1, 8);
        chk("R7", "update applied after", int'(rsp_count), 0);
    endtask

    task automatic t_nondep();
        lookup(12, 1'b0, 8);
        chk("R9", "nondep stall", int'(fetch_stall), 0);
        chk("R9", "nondep spec", int'(spec_allow), 0);
        chk("R6", "nondep rsp_valid", int'(rsp_valid), 1);
        @(negedge clk);
        chk("R6", "rsp_valid drops", int'(rsp_valid), 0);
    endtask

    task automatic t_isolation();
        update(20, 1'b0);
        update(22, 1'b0);
        lookup(21, 1'b1, 8);
        chk("R10", "neighbour untouched", int'(rsp_count), 15);
        lookup(20, 1'b1, 8);
        chk("R10", "target cleared", int'(rsp_count), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_clear();
        t_increment();
        t_saturate();
        t_thresh0();
        t_same_cycle();
        t_nondep();
        t_isolation();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule